// File: doc/BRIEF.md
# I/O Window Address Translator

The block sits between a 32-bit CPU memory bus and a 16-bit-address I/O port bus. A CPU access that falls inside an 8 MB window starting at 0x8000_0000 is turned into a single I/O port access. The port address comes from the CPU address by one of two rules. A map-select input picks the rule. In flat mode the port number is the low half of the address. In folded mode the page-number bits are pulled down next to the low offset bits, so each 4 KB page of the window reaches a 32-port group.

Data on 16-bit and 32-bit accesses can be lane-swapped. When the byte-order input requests big-endian ordering, a halfword has its two bytes exchanged and a word has all four bytes reversed. This applies to write data and to read data alike. Byte accesses pass through unchanged.

A read of the single address 0xBFFF_FFF0 fetches a vector from an external interrupt controller through a request/acknowledge pair. Every other access completes at once with zero data. The translation is registered: strobes and addresses appear one clock after the CPU request, and each access ends with a one-cycle ready pulse. The CPU is expected to issue a new request only while no access is outstanding.

Top module: `io_window_xlate`

## Requirements
- R1: While reset is asserted, `io_req`, `iack_req` and `cpu_ready` are low and `cpu_rdata` is zero.
- R2: A request with `cpu_addr` in 0x8000_0000..0x807F_FFFF raises `io_req` one clock later and holds it until `io_ack` is sampled high. A request anywhere else never raises `io_req`.
- R3: With `map_noncontig` = 0 at request time, `io_addr` equals `cpu_addr[15:0]`.
- R4: With `map_noncontig` = 1 at request time, `io_addr` equals {`cpu_addr[22:12]`, `cpu_addr[4:0]`}.
- R5: `map_noncontig` is sampled only when the request is taken. `io_addr` stays stable while `io_req` is high, even if the map input changes.
- R6: Size codes are 0 = byte, 1 = halfword, 2 or 3 = word. With `big_endian` = 1, write data goes out as follows: a halfword as {16'h0, d[7:0], d[15:8]}, a word as {d[7:0], d[15:8], d[23:16], d[31:24]}, a byte as {24'h0, d[7:0]}. With `big_endian` = 0 the lanes are not swapped, but halfwords and bytes are still zero-extended. On reads `io_wdata` is zero.
- R7: Read data returned on `io_rdata` reaches `cpu_rdata` with the same size-dependent swap and zero-extension as R6, using the size and byte order sampled at request time.
- R8: `cpu_ready` pulses for one cycle on the clock after the acknowledge is sampled. `cpu_rdata` is zero whenever `cpu_ready` is low, and it is zero on completion of a write.
- R9: A read of exactly 0xBFFF_FFF0 raises `iack_req` one clock later, held until `iack_ack`. The zero-extended `iack_vec` is then returned, swapped as in R7.
- R10: Reads of 0xBFFF_FFF1..0xBFFF_FFF3, and any write to 0xBFFF_FFF0..0xBFFF_FFF3, raise no strobe. They complete with `cpu_ready` one clock later and zero data.
- R11: A request outside both decoded regions raises no strobe and completes with `cpu_ready` one clock later and zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU access request, one cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU physical address |
| cpu_size | input | 2 | Access size code (0 byte, 1 half, 2/3 word) |
| cpu_wdata | input | 32 | CPU write data |
| map_noncontig | input | 1 | 1 selects folded port mapping |
| big_endian | input | 1 | 1 enables lane swapping |
| cpu_rdata | output | 32 | Read data, valid with cpu_ready |
| cpu_ready | output | 1 | Access completion pulse |
| io_req | output | 1 | I/O port access strobe |
| io_we | output | 1 | I/O write |
| io_addr | output | 16 | I/O port address |
| io_size | output | 2 | I/O access size code |
| io_wdata | output | 32 | Swapped I/O write data |
| io_rdata | input | 32 | I/O read data |
| io_ack | input | 1 | I/O access done |
| iack_req | output | 1 | Interrupt-acknowledge request |
| iack_vec | input | 8 | Vector from the interrupt controller |
| iack_ack | input | 1 | Vector valid |

## Verification
The address path is driven with window addresses whose page bits and low bits differ, so the flat and folded rules give different port numbers. It is also driven at the window's last byte and at the addresses just past each end, which separates a correct window compare from an off-by-one. Data is sent through every size with both byte orders, using all-distinct byte values, so a missing, partial or misplaced swap shows up as a wrong byte. The interrupt-acknowledge address is hit with every size and with its neighbours and writes; flipping the map input while an access waits shows whether the mode was latched.

// File: rtl/io_xlate_pkg.sv
package io_xlate_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD3 = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IO   = 2'd1,
    ST_IACK = 2'd2
  } xlate_state_e;
endpackage

// File: rtl/io_region_decode.sv
module io_region_decode #(
  parameter int               ADDR_W    = 32,
  parameter int               WIN_LOG2  = 23,
  parameter logic [31:0]      WIN_BASE  = 32'h8000_0000,
  parameter logic [31:0]      IACK_ADDR = 32'hBFFF_FFF0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              win_hit,
  output logic              iack_hit
);
  localparam int TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

  assign win_hit  = (addr[ADDR_W-1:WIN_LOG2] == WIN_TAG);
  assign iack_hit = (addr == IACK_ADDR[ADDR_W-1:0]);
endmodule

// File: rtl/io_addr_map.sv
module io_addr_map #(
  parameter int ADDR_W     = 32,
  parameter int IO_ADDR_W  = 16,
  parameter int WIN_LOG2   = 23,
  parameter int PAGE_SHIFT = 12,
  parameter int FOLD       = 7,
  parameter int LOW_BITS   = 5
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 noncontig,
  output logic [IO_ADDR_W-1:0] io_addr
);
  localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] LOW_MASK  = (ONE << LOW_BITS) - ONE;
  localparam logic [ADDR_W-1:0] PAGE_MASK = (ONE << WIN_LOG2) - (ONE << PAGE_SHIFT);

  logic [IO_ADDR_W-1:0] flat_addr;
  logic [IO_ADDR_W-1:0] fold_addr;

  assign flat_addr = addr[IO_ADDR_W-1:0];
  assign fold_addr = IO_ADDR_W'((addr & LOW_MASK) | ((addr & PAGE_MASK) >> FOLD));
  assign io_addr   = noncontig ? fold_addr : flat_addr;
endmodule

// File: rtl/io_lane_swap.sv
module io_lane_swap
  import io_xlate_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        size,
  input  logic              swap_en,
  output logic [DATA_W-1:0] dout
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] word_rev;
  logic [DATA_W-1:0] half_val;
  logic [DATA_W-1:0] byte_val;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign word_rev[g*8 +: 8] = din[(NB-1-g)*8 +: 8];
  end

  always_comb begin
    half_val       = '0;
    half_val[15:0] = swap_en ? {din[7:0], din[15:8]} : din[15:0];
    byte_val       = '0;
    byte_val[7:0]  = din[7:0];
  end

  always_comb begin
    case (xfer_size_e'(size))
      SZ_BYTE: dout = byte_val;
      SZ_HALF: dout = half_val;
      default: dout = swap_en ? word_rev : din;
    endcase
  end
endmodule

// File: rtl/io_window_xlate.sv
module io_window_xlate
  import io_xlate_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          IO_ADDR_W  = 16,
  parameter int          VEC_W      = 8,
  parameter int          WIN_LOG2   = 23,
  parameter int          PAGE_SHIFT = 12,
  parameter int          FOLD       = 7,
  parameter int          LOW_BITS   = 5,
  parameter logic [31:0] WIN_BASE   = 32'h8000_0000,
  parameter logic [31:0] IACK_ADDR  = 32'hBFFF_FFF0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic [ADDR_W-1:0]    cpu_addr,
  input  logic [1:0]           cpu_size,
  input  logic [DATA_W-1:0]    cpu_wdata,
  input  logic                 map_noncontig,
  input  logic                 big_endian,
  output logic [DATA_W-1:0]    cpu_rdata,
  output logic                 cpu_ready,
  output logic                 io_req,
  output logic                 io_we,
  output logic [IO_ADDR_W-1:0] io_addr,
  output logic [1:0]           io_size,
  output logic [DATA_W-1:0]    io_wdata,
  input  logic [DATA_W-1:0]    io_rdata,
  input  logic                 io_ack,
  output logic                 iack_req,
  input  logic [VEC_W-1:0]     iack_vec,
  input  logic                 iack_ack
);
  localparam int VEC_PAD = DATA_W - VEC_W;

  xlate_state_e         state_q, state_d;
  logic                 io_req_q, io_req_d;
  logic                 io_we_q, io_we_d;
  logic [IO_ADDR_W-1:0] io_addr_q, io_addr_d;
  logic [1:0]           io_size_q, io_size_d;
  logic [DATA_W-1:0]    io_wdata_q, io_wdata_d;
  logic                 iack_req_q, iack_req_d;
  logic                 ready_q, ready_d;
  logic [DATA_W-1:0]    rdata_q, rdata_d;
  logic [1:0]           size_q, size_d;
  logic                 be_q, be_d;

  logic                 win_hit, iack_hit;
  logic [IO_ADDR_W-1:0] mapped_addr;
  logic [DATA_W-1:0]    wr_swapped;
  logic [DATA_W-1:0]    rd_source;
  logic [DATA_W-1:0]    rd_swapped;
  logic                 take_req;

  io_region_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_LOG2 (WIN_LOG2),
    .WIN_BASE (WIN_BASE),
    .IACK_ADDR(IACK_ADDR)
  ) u_decode (
    .addr    (cpu_addr),
    .win_hit (win_hit),
    .iack_hit(iack_hit)
  );

  io_addr_map #(
    .ADDR_W    (ADDR_W),
    .IO_ADDR_W (IO_ADDR_W),
    .WIN_LOG2  (WIN_LOG2),
    .PAGE_SHIFT(PAGE_SHIFT),
    .FOLD      (FOLD),
    .LOW_BITS  (LOW_BITS)
  ) u_map (
    .addr     (cpu_addr),
    .noncontig(map_noncontig),
    .io_addr  (mapped_addr)
  );

  io_lane_swap #(.DATA_W(DATA_W)) u_wr_swap (
    .din    (cpu_wdata),
    .size   (cpu_size),
    .swap_en(big_endian),
    .dout   (wr_swapped)
  );

  assign rd_source = (state_q == ST_IACK) ? {{VEC_PAD{1'b0}}, iack_vec} : io_rdata;

  io_lane_swap #(.DATA_W(DATA_W)) u_rd_swap (
    .din    (rd_source),
    .size   (size_q),
    .swap_en(be_q),
    .dout   (rd_swapped)
  );

  assign take_req = (state_q == ST_IDLE) && cpu_req;

  always_comb begin
    state_d    = state_q;
    io_req_d   = io_req_q;
    io_we_d    = io_we_q;
    io_addr_d  = io_addr_q;
    io_size_d  = io_size_q;
    io_wdata_d = io_wdata_q;
    iack_req_d = iack_req_q;
    size_d     = size_q;
    be_d       = be_q;
    ready_d    = 1'b0;
    rdata_d    = '0;
    case (state_q)
      ST_IDLE: begin
        if (take_req) begin
          size_d = cpu_size;
          be_d   = big_endian;
          if (win_hit) begin
            state_d    = ST_IO;
            io_req_d   = 1'b1;
            io_we_d    = cpu_we;
            io_addr_d  = mapped_addr;
            io_size_d  = cpu_size;
            io_wdata_d = cpu_we ? wr_swapped : '0;
          end else if (iack_hit && !cpu_we) begin
            state_d    = ST_IACK;
            iack_req_d = 1'b1;
          end else begin
            ready_d = 1'b1;
          end
        end
      end
      ST_IO: begin
        if (io_ack) begin
          state_d  = ST_IDLE;
          io_req_d = 1'b0;
          ready_d  = 1'b1;
          rdata_d  = io_we_q ? '0 : rd_swapped;
        end
      end
      ST_IACK: begin
        if (iack_ack) begin
          state_d    = ST_IDLE;
          iack_req_d = 1'b0;
          ready_d    = 1'b1;
          rdata_d    = rd_swapped;
        end
      end
      default: begin
        state_d    = ST_IDLE;
        io_req_d   = 1'b0;
        iack_req_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      io_req_q   <= 1'b0;
      io_we_q    <= 1'b0;
      io_addr_q  <= '0;
      io_size_q  <= '0;
      io_wdata_q <= '0;
      iack_req_q <= 1'b0;
      ready_q    <= 1'b0;
      rdata_q    <= '0;
      size_q     <= '0;
      be_q       <= 1'b0;
    end else begin
      state_q    <= state_d;
      io_req_q   <= io_req_d;
      iack_req_q <= iack_req_d;
      ready_q    <= ready_d;
      rdata_q    <= rdata_d;
      if (take_req) begin
        io_we_q    <= io_we_d;
        io_addr_q  <= io_addr_d;
        io_size_q  <= io_size_d;
        io_wdata_q <= io_wdata_d;
        size_q     <= size_d;
        be_q       <= be_d;
      end
    end
  end

  assign cpu_rdata = rdata_q;
  assign cpu_ready = ready_q;
  assign io_req    = io_req_q;
  assign io_we     = io_we_q;
  assign io_addr   = io_addr_q;
  assign io_size   = io_size_q;
  assign io_wdata  = io_wdata_q;
  assign iack_req  = iack_req_q;
endmodule

// File: rtl/io_window_xlate_chk.sv
module io_window_xlate_chk #(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          IO_ADDR_W  = 16,
  parameter int          VEC_W      = 8,
  parameter int          WIN_LOG2   = 23,
  parameter int          PAGE_SHIFT = 12,
  parameter int          LOW_BITS   = 5,
  parameter logic [31:0] WIN_BASE   = 32'h8000_0000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_req,
  input logic                 cpu_we,
  input logic [ADDR_W-1:0]    cpu_addr,
  input logic                 map_noncontig,
  input logic [DATA_W-1:0]    cpu_rdata,
  input logic                 cpu_ready,
  input logic                 io_req,
  input logic                 io_we,
  input logic [IO_ADDR_W-1:0] io_addr,
  input logic                 io_ack,
  input logic                 iack_req,
  input logic                 iack_ack
);
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !io_ack |=> io_req);

  a_r2_window_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_req) |-> $past(cpu_req) &&
      ($past(cpu_addr[ADDR_W-1:WIN_LOG2]) == WIN_BASE[ADDR_W-1:WIN_LOG2]));

  a_r3_flat_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_req) && !$past(map_noncontig) |-> io_addr == $past(cpu_addr[IO_ADDR_W-1:0]));

  a_r4_fold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(io_req) && $past(map_noncontig) |->
      (io_addr[LOW_BITS-1:0] == $past(cpu_addr[LOW_BITS-1:0])) &&
      (io_addr[IO_ADDR_W-1:LOW_BITS] == $past(cpu_addr[WIN_LOG2-1:PAGE_SHIFT])));

  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !io_ack |=> $stable(io_addr));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> cpu_rdata == '0);

  a_r8_io_done: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && io_ack |=> cpu_ready && !io_req);

  a_r8_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && io_ack && io_we |=> cpu_rdata == '0);

  a_r9_iack_done: assert property (@(posedge clk) disable iff (!rst_n)
    iack_req && iack_ack |=> cpu_ready && !iack_req);

  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_req && iack_req));

  a_r10_iack_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack_req) |-> $past(cpu_req) && !$past(cpu_we));
endmodule

bind io_window_xlate io_window_xlate_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .IO_ADDR_W (IO_ADDR_W),
  .VEC_W     (VEC_W),
  .WIN_LOG2  (WIN_LOG2),
  .PAGE_SHIFT(PAGE_SHIFT),
  .LOW_BITS  (LOW_BITS),
  .WIN_BASE  (WIN_BASE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_req      (cpu_req),
  .cpu_we       (cpu_we),
  .cpu_addr     (cpu_addr),
  .map_noncontig(map_noncontig),
  .cpu_rdata    (cpu_rdata),
  .cpu_ready    (cpu_ready),
  .io_req       (io_req),
  .io_we        (io_we),
  .io_addr      (io_addr),
  .io_ack       (io_ack),
  .iack_req     (iack_req),
  .iack_ack     (iack_ack)
);

// File: tb/io_window_xlate_tb.sv
`timescale 1ns/1ps
module io_window_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we, map_noncontig, big_endian;
  logic [31:0] cpu_addr, cpu_wdata, io_rdata;
  logic [1:0]  cpu_size;
  logic        io_ack, iack_ack;
  logic [7:0]  iack_vec;
  logic [31:0] cpu_rdata, io_wdata;
  logic        cpu_ready, io_req, io_we, iack_req;
  logic [15:0] io_addr;
  logic [1:0]  io_size;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  io_window_xlate dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
    .map_noncontig(map_noncontig), .big_endian(big_endian),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_size(io_size),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack),
    .iack_req(iack_req), .iack_vec(iack_vec), .iack_ack(iack_ack)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [31:0] d, input logic [1:0] sz,
                                        input logic be);
    if (sz == 2'd0) return {24'h0, d[7:0]};
    if (sz == 2'd1) return be ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
    return be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
  endfunction

  task automatic issue(input logic [31:0] a, input logic we, input logic [1:0] sz,
                       input logic [31:0] wd, input logic map, input logic be);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_size = sz;
    cpu_wdata = wd; map_noncontig = map; big_endian = be;
    @(negedge clk);
    cpu_req = 1'b0; cpu_addr = 32'h0; cpu_wdata = 32'hDEAD_BEEF;
  endtask

  task automatic io_xfer(input logic [31:0] a, input logic we, input logic [1:0] sz,
                         input logic [31:0] wd, input logic map, input logic be,
                         input logic [31:0] resp);
    logic [15:0] exp_a;
    exp_a = map ? {a[22:12], a[4:0]} : a[15:0];
    issue(a, we, sz, wd, map, be);
    chk("R2 io_req raised", {31'h0, io_req}, 32'h1);
    chk("R9 no iack on io access", {31'h0, iack_req}, 32'h0);
    if (map) chk("R4 folded io_addr", {16'h0, io_addr}, {16'h0, exp_a});
    else     chk("R3 flat io_addr", {16'h0, io_addr}, {16'h0, exp_a});
    chk("R6 io_wdata", io_wdata, we ? lanes(wd, sz, be) : 32'h0);
    chk("R2 io_we", {31'h0, io_we}, {31'h0, we});
    map_noncontig = ~map;
    big_endian = ~be;
    @(negedge clk);
    chk("R5 io_addr stable after map change", {16'h0, io_addr}, {16'h0, exp_a});
    chk("R2 io_req held", {31'h0, io_req}, 32'h1);
    chk("R8 no early ready", {31'h0, cpu_ready}, 32'h0);
    io_ack = 1'b1; io_rdata = resp;
    @(negedge clk);
    io_ack = 1'b0; io_rdata = 32'h0;
    chk("R8 ready pulse", {31'h0, cpu_ready}, 32'h1);
    chk("R7 cpu_rdata", cpu_rdata, we ? 32'h0 : lanes(resp, sz, be));
    chk("R2 io_req dropped", {31'h0, io_req}, 32'h0);
    @(negedge clk);
    chk("R8 ready one cycle", {31'h0, cpu_ready}, 32'h0);
    chk("R8 rdata zero when idle", cpu_rdata, 32'h0);
  endtask

  task automatic quick_xfer(input string tag, input logic [31:0] a, input logic we,
                            input logic [1:0] sz);
    issue(a, we, sz, 32'hA5A5_A5A5, 1'b0, 1'b1);
    chk({tag, " ready next cycle"}, {31'h0, cpu_ready}, 32'h1);
    chk({tag, " zero data"}, cpu_rdata, 32'h0);
    chk({tag, " no io_req"}, {31'h0, io_req}, 32'h0);
    chk({tag, " no iack_req"}, {31'h0, iack_req}, 32'h0);
  endtask

  task automatic iack_xfer(input logic [1:0] sz, input logic be, input logic [7:0] vec);
    issue(32'hBFFF_FFF0, 1'b0, sz, 32'h0, 1'b0, be);
    chk("R9 iack_req raised", {31'h0, iack_req}, 32'h1);
    chk("R9 no io_req", {31'h0, io_req}, 32'h0);
    @(negedge clk);
    chk("R9 iack_req held", {31'h0, iack_req}, 32'h1);
    iack_ack = 1'b1; iack_vec = vec;
    @(negedge clk);
    iack_ack = 1'b0; iack_vec = 8'h0;
    chk("R9 iack ready", {31'h0, cpu_ready}, 32'h1);
    chk("R9 vector lanes", cpu_rdata, lanes({24'h0, vec}, sz, be));
    chk("R9 iack_req dropped", {31'h0, iack_req}, 32'h0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = 32'h0;
    cpu_size = 2'd0; cpu_wdata = 32'h0; map_noncontig = 1'b0; big_endian = 1'b0;
    io_rdata = 32'h0; io_ack = 1'b0; iack_vec = 8'h0; iack_ack = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 io_req in reset", {31'h0, io_req}, 32'h0);
    chk("R1 iack_req in reset", {31'h0, iack_req}, 32'h0);
    chk("R1 cpu_ready in reset", {31'h0, cpu_ready}, 32'h0);
    chk("R1 cpu_rdata in reset", cpu_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    io_xfer(32'h8000_03F8, 1'b1, 2'd0, 32'h1122_335A, 1'b0, 1'b0, 32'h0);
    io_xfer(32'h8012_3017, 1'b0, 2'd0, 32'h0, 1'b1, 1'b1, 32'hFFFF_FF7E);
    io_xfer(32'h8005_A6C2, 1'b1, 2'd1, 32'h7777_BEEF, 1'b1, 1'b1, 32'h0);
    io_xfer(32'h8000_1234, 1'b0, 2'd1, 32'h0, 1'b0, 1'b1, 32'h9999_1234);
    io_xfer(32'h8000_1234, 1'b0, 2'd1, 32'h0, 1'b0, 1'b0, 32'h9999_1234);
    io_xfer(32'h8044_4008, 1'b1, 2'd2, 32'h1122_3344, 1'b1, 1'b1, 32'h0);
    io_xfer(32'h8044_4008, 1'b1, 2'd3, 32'h1122_3344, 1'b0, 1'b0, 32'h0);
    io_xfer(32'h8000_0CF8, 1'b0, 2'd2, 32'h0, 1'b0, 1'b1, 32'hA1B2_C3D4);
    io_xfer(32'h8000_0CF8, 1'b0, 2'd3, 32'h0, 1'b1, 1'b0, 32'hA1B2_C3D4);
    io_xfer(32'h807F_FFFF, 1'b0, 2'd0, 32'h0, 1'b1, 1'b0, 32'h0000_0042);
    io_xfer(32'h8000_0000, 1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 32'h0000_0013);

    quick_xfer("R11 past window end", 32'h8080_0000, 1'b0, 2'd2);
    quick_xfer("R11 below window", 32'h7FFF_FFFC, 1'b1, 2'd2);
    quick_xfer("R11 far away", 32'h0000_03F8, 1'b0, 2'd0);

    iack_xfer(2'd0, 1'b1, 8'h21);
    iack_xfer(2'd1, 1'b1, 8'h21);
    iack_xfer(2'd2, 1'b1, 8'h21);
    iack_xfer(2'd2, 1'b0, 8'h21);
    iack_xfer(2'd1, 1'b0, 8'h5C);

    quick_xfer("R10 iack neighbour read", 32'hBFFF_FFF1, 1'b0, 2'd0);
    quick_xfer("R10 iack last byte read", 32'hBFFF_FFF3, 1'b0, 2'd0);
    quick_xfer("R10 iack write ignored", 32'hBFFF_FFF0, 1'b1, 2'd2);
    @(negedge clk);
    chk("R10 no late iack_req", {31'h0, iack_req}, 32'h0);
    chk("R8 idle rdata zero", cpu_rdata, 32'h0);

    summary();
    $finish;
  end
endmodule